// File: doc/BRIEF.md
# Exception Prioritiser and Mode-Entry Unit

This block sits in the control path of a processor core. Seven exception sources can raise a request in the same cycle. The sources are reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software interrupt. The block picks the one to service in this cycle. It then works out every piece of state the core must load to enter that exception's handler.

Two masks come from the current status word: the normal-interrupt mask in bit 7 and the fast-interrupt mask in bit 6. A masked interrupt drops out of the contest, and lower sources then compete as if it were absent.

The winner sets the mode to enter and the status word to install in the core. It also sets the vector address to load into the program counter. For every exception except reset, the block also emits the following:
- the status word to save;
- the return address;
- a one-hot write strobe that selects the saved-status and link registers of the target mode.

The core owns those banked registers. All outputs are registered, so results appear one clock after the requests are sampled.

Top module: `exc_entry_unit`

## Requirements
- R1: The service order, highest first, is reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt. Undefined instruction is placed ahead of software interrupt for the case where both are raised.
- R2: A normal-interrupt request is ignored while `cur_psr[7]` is 1, and a fast-interrupt request is ignored while `cur_psr[6]` is 1. A masked request never blocks a lower-priority request.
- R3: The entered mode, given on `new_mode`, is 10011 for reset and 10111 for either abort. It is 10001 for fast interrupt, 10010 for normal interrupt, 11011 for undefined instruction and 10011 for software interrupt.
- R4: `vector_pc` equals `VEC_BASE` plus an offset for the exception. The offsets are 0x00 for reset, 0x04 for undefined instruction, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt.
- R5: `new_psr` is built from `cur_psr` and the entered mode as follows:
  - bits 31:8 are copied from `cur_psr`;
  - bit 7 is forced to 1;
  - bit 6 is forced to 1 on reset or fast-interrupt entry and is copied otherwise;
  - bit 5 is forced to 0;
  - bits 4:0 hold the entered mode.
- R6: On a non-reset entry, `saved_psr` equals `cur_psr` and `link_addr` equals `cur_pc`, both taken in the request cycle. `bank_we` has exactly one bit set for the target mode: bit 0 fast interrupt, bit 1 normal interrupt, bit 2 supervisor, bit 3 abort, bit 4 undefined.
- R7: A reset entry sets `entry_valid` but leaves `bank_we` all zero.
- R8: Every output reflects the requests and inputs present at the previous rising clock edge. `entry_valid` is 1 for every cycle that follows a cycle with a serviceable request, including back-to-back cycles.
- R9: In a cycle with no serviceable request, the next cycle has `entry_valid` and `bank_we` at 0. `new_mode`, `new_psr`, `saved_psr`, `link_addr` and `vector_pc` keep their previous values.
- R10: While `rst` is high at a rising edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_reset | input | 1 | Reset exception request |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_swi | input | 1 | Software interrupt request |
| req_und | input | 1 | Undefined instruction request |
| cur_psr | input | XLEN | Current status word (flags 31:28, masks 7 and 6, state bit 5, mode 4:0) |
| cur_pc | input | XLEN | Return address to save for the exception |
| entry_valid | output | 1 | An exception was taken; load the outputs below |
| new_mode | output | 5 | Mode entered |
| new_psr | output | XLEN | Status word to install |
| saved_psr | output | XLEN | Status word for the target mode's saved-status register |
| link_addr | output | XLEN | Value for the target mode's link register |
| bank_we | output | NBANK | One-hot write strobe selecting the target mode's bank |
| vector_pc | output | XLEN | Handler vector address for the program counter |

## Verification
Single requests are applied one source at a time. Each of these separates the mode, vector and bank strobe of one source from all the others. Overlapping requests come next: all seven at once, then a descending staircase of subsets. Each subset removes the current winner, so a wrong rank anywhere in the order shows up.

Mask patterns have two forms:
- a masked interrupt raised alone, which tells ignoring apart from servicing;
- a masked interrupt beside an unmasked lower request, which tells dropping out apart from blocking.

Status words with the flag bits and the state bit set show whether bits are copied or forced. Idle and back-to-back cycles show whether the outputs hold or update.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;
  localparam int MODE_W = 5;
  localparam int NBANK = 5;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // bank strobe bit positions
  localparam int BANK_FIQ = 0;
  localparam int BANK_IRQ = 1;
  localparam int BANK_SVC = 2;
  localparam int BANK_ABT = 3;
  localparam int BANK_UND = 4;

  typedef enum logic [2:0] {
    K_NONE, K_RESET, K_DABT, K_FIQ, K_IRQ, K_PABT, K_UND, K_SWI
  } kind_e;

  typedef struct packed {
    logic rst_r;
    logic dabt;
    logic fiq;
    logic irq;
    logic pabt;
    logic swi;
    logic und;
  } req_t;
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_pkg::*;
(
  input  req_t  req,
  input  logic  mask_irq,
  input  logic  mask_fiq,
  output kind_e kind
);
  logic fiq_live, irq_live;

  assign fiq_live = req.fiq & ~mask_fiq;
  assign irq_live = req.irq & ~mask_irq;

  always_comb begin
    if (req.rst_r)      kind = K_RESET;
    else if (req.dabt)  kind = K_DABT;
    else if (fiq_live)  kind = K_FIQ;
    else if (irq_live)  kind = K_IRQ;
    else if (req.pabt)  kind = K_PABT;
    else if (req.und)   kind = K_UND;
    else if (req.swi)   kind = K_SWI;
    else                kind = K_NONE;
  end
endmodule

// File: rtl/exc_target_map.sv
module exc_target_map
  import exc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NB       = NBANK,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  kind_e             kind,
  output logic              take,
  output logic [MODE_W-1:0] mode,
  output logic [XLEN-1:0]   vec,
  output logic              set_f,
  output logic [NB-1:0]     bank_oh
);
  localparam int IDX_W = $clog2(NB);

  logic [7:0]       off;
  logic [IDX_W-1:0] bank_idx;
  logic             has_bank;

  always_comb begin
    take     = 1'b1;
    has_bank = 1'b1;
    set_f    = 1'b0;
    mode     = MODE_SVC;
    off      = 8'h00;
    bank_idx = IDX_W'(BANK_SVC);
    unique case (kind)
      K_RESET: begin mode = MODE_SVC; off = 8'h00; set_f = 1'b1; has_bank = 1'b0; end
      K_DABT:  begin mode = MODE_ABT; off = 8'h10; bank_idx = IDX_W'(BANK_ABT); end
      K_FIQ:   begin mode = MODE_FIQ; off = 8'h1C; set_f = 1'b1; bank_idx = IDX_W'(BANK_FIQ); end
      K_IRQ:   begin mode = MODE_IRQ; off = 8'h18; bank_idx = IDX_W'(BANK_IRQ); end
      K_PABT:  begin mode = MODE_ABT; off = 8'h0C; bank_idx = IDX_W'(BANK_ABT); end
      K_UND:   begin mode = MODE_UND; off = 8'h04; bank_idx = IDX_W'(BANK_UND); end
      K_SWI:   begin mode = MODE_SVC; off = 8'h08; bank_idx = IDX_W'(BANK_SVC); end
      default: begin take = 1'b0; has_bank = 1'b0; end
    endcase
  end

  assign vec = VEC_BASE + XLEN'(off);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign bank_oh[g] = has_bank && (bank_idx == IDX_W'(g));
  end
endmodule

// File: rtl/exc_psr_build.sv
module exc_psr_build
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   cur_psr,
  input  logic [MODE_W-1:0] mode,
  input  logic              set_f,
  output logic [XLEN-1:0]   new_psr
);
  always_comb begin
    new_psr               = cur_psr;
    new_psr[BIT_I]        = 1'b1;
    new_psr[BIT_F]        = cur_psr[BIT_F] | set_f;
    new_psr[BIT_T]        = 1'b0;
    new_psr[MODE_W-1:0]   = mode;
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NB   = NBANK,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_reset,
  input  logic              req_dabt,
  input  logic              req_fiq,
  input  logic              req_irq,
  input  logic              req_pabt,
  input  logic              req_swi,
  input  logic              req_und,
  input  logic [XLEN-1:0]   cur_psr,
  input  logic [XLEN-1:0]   cur_pc,
  output logic              entry_valid,
  output logic [MODE_W-1:0] new_mode,
  output logic [XLEN-1:0]   new_psr,
  output logic [XLEN-1:0]   saved_psr,
  output logic [XLEN-1:0]   link_addr,
  output logic [NB-1:0]     bank_we,
  output logic [XLEN-1:0]   vector_pc
);
  req_t              req;
  kind_e             kind;
  logic              take;
  logic [MODE_W-1:0] t_mode;
  logic [XLEN-1:0]   t_vec;
  logic              t_set_f;
  logic [NB-1:0]     t_bank;
  logic [XLEN-1:0]   t_psr;

  assign req = '{rst_r: req_reset, dabt: req_dabt, fiq: req_fiq, irq: req_irq,
                 pabt: req_pabt, swi: req_swi, und: req_und};

  exc_prio_sel u_sel (
    .req      (req),
    .mask_irq (cur_psr[BIT_I]),
    .mask_fiq (cur_psr[BIT_F]),
    .kind     (kind)
  );

  exc_target_map #(.XLEN(XLEN), .NB(NB), .VEC_BASE(VEC_BASE)) u_map (
    .kind    (kind),
    .take    (take),
    .mode    (t_mode),
    .vec     (t_vec),
    .set_f   (t_set_f),
    .bank_oh (t_bank)
  );

  exc_psr_build #(.XLEN(XLEN)) u_psr (
    .cur_psr (cur_psr),
    .mode    (t_mode),
    .set_f   (t_set_f),
    .new_psr (t_psr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_valid <= 1'b0;
      new_mode    <= '0;
      new_psr     <= '0;
      saved_psr   <= '0;
      link_addr   <= '0;
      bank_we     <= '0;
      vector_pc   <= '0;
    end else begin
      entry_valid <= take;
      bank_we     <= take ? t_bank : '0;
      if (take) begin
        new_mode  <= t_mode;
        new_psr   <= t_psr;
        saved_psr <= cur_psr;
        link_addr <= cur_pc;
        vector_pc <= t_vec;
      end
    end
  end

  // R2
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == K_IRQ) |-> !cur_psr[BIT_I]);
  // R2
  fiq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == K_FIQ) |-> !cur_psr[BIT_F]);
  // R6
  bank_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_we));
  // R6
  bank_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (bank_we != '0) |-> entry_valid);
  // R7
  reset_no_bank_chk: assert property (@(posedge clk) disable iff (rst)
    req_reset |=> (entry_valid && bank_we == '0 && vector_pc == VEC_BASE));
  // R5
  entry_psr_chk: assert property (@(posedge clk) disable iff (rst)
    entry_valid |-> (new_psr[BIT_I] && !new_psr[BIT_T] && new_psr[MODE_W-1:0] == new_mode));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> (!entry_valid && $stable(vector_pc) && $stable(new_mode)));
endmodule

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] req = '0; // {reset,dabt,fiq,irq,pabt,swi,und}
  logic [XLEN-1:0] cur_psr = '0;
  logic [XLEN-1:0] cur_pc  = '0;
  logic entry_valid;
  logic [4:0] new_mode;
  logic [XLEN-1:0] new_psr, saved_psr, link_addr, vector_pc;
  logic [4:0] bank_we;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_entry_unit u_dut (
    .clk(clk), .rst(rst),
    .req_reset(req[6]), .req_dabt(req[5]), .req_fiq(req[4]), .req_irq(req[3]),
    .req_pabt(req[2]), .req_swi(req[1]), .req_und(req[0]),
    .cur_psr(cur_psr), .cur_pc(cur_pc),
    .entry_valid(entry_valid), .new_mode(new_mode), .new_psr(new_psr),
    .saved_psr(saved_psr), .link_addr(link_addr), .bank_we(bank_we),
    .vector_pc(vector_pc)
  );

  typedef struct packed {
    logic [6:0]  req;
    logic [31:0] psr;
    logic        valid;
    logic [4:0]  mode;
    logic [7:0]  vec;
    logic [4:0]  bank;
    logic        setf;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{7'b0000001, 32'hA000_0030, 1'b1, 5'b11011, 8'h04, 5'b10000, 1'b0}, // und
    '{7'b0000010, 32'h5000_0010, 1'b1, 5'b10011, 8'h08, 5'b00100, 1'b0}, // swi
    '{7'b0000100, 32'h0000_0010, 1'b1, 5'b10111, 8'h0C, 5'b01000, 1'b0}, // pabt
    '{7'b0100000, 32'hF000_0013, 1'b1, 5'b10111, 8'h10, 5'b01000, 1'b0}, // dabt
    '{7'b0001000, 32'h3000_0030, 1'b1, 5'b10010, 8'h18, 5'b00010, 1'b0}, // irq
    '{7'b0010000, 32'h8000_0010, 1'b1, 5'b10001, 8'h1C, 5'b00001, 1'b1}, // fiq
    '{7'b1111111, 32'hC000_0010, 1'b1, 5'b10011, 8'h00, 5'b00000, 1'b1}, // all
    '{7'b0111111, 32'h0000_0010, 1'b1, 5'b10111, 8'h10, 5'b01000, 1'b0}, // dabt top
    '{7'b0011111, 32'h0000_0010, 1'b1, 5'b10001, 8'h1C, 5'b00001, 1'b1}, // fiq top
    '{7'b0001111, 32'h0000_0010, 1'b1, 5'b10010, 8'h18, 5'b00010, 1'b0}, // irq top
    '{7'b0000111, 32'h0000_0010, 1'b1, 5'b10111, 8'h0C, 5'b01000, 1'b0}, // pabt top
    '{7'b0000011, 32'h0000_0010, 1'b1, 5'b11011, 8'h04, 5'b10000, 1'b0}, // und>swi
    '{7'b0001000, 32'h0000_0090, 1'b0, 5'b00000, 8'h00, 5'b00000, 1'b0}, // irq masked
    '{7'b0010000, 32'h0000_0050, 1'b0, 5'b00000, 8'h00, 5'b00000, 1'b0}, // fiq masked
    '{7'b0011000, 32'h0000_0050, 1'b1, 5'b10010, 8'h18, 5'b00010, 1'b1}, // fiq masked, irq
    '{7'b0001100, 32'h2000_0090, 1'b1, 5'b10111, 8'h0C, 5'b01000, 1'b0}  // irq masked, pabt
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_psr(input logic [31:0] p, input logic [4:0] m, input logic sf);
    logic [31:0] r;
    r = p;
    r[7] = 1'b1;
    r[6] = p[6] | sf;
    r[5] = 1'b0;
    r[4:0] = m;
    return r;
  endfunction

  logic [4:0]  last_mode;
  logic [31:0] last_vec, last_psr, last_saved, last_link;

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 valid", 32'(entry_valid), 0);
    chk("R10 mode", 32'(new_mode), 0);
    chk("R10 vector", vector_pc, 0);
    chk("R10 bank", 32'(bank_we), 0);
    chk("R10 newpsr", new_psr, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      last_mode = new_mode; last_vec = vector_pc; last_psr = new_psr;
      last_saved = saved_psr; last_link = link_addr;
      req = TBL[i].req;
      cur_psr = TBL[i].psr;
      cur_pc = 32'h0000_8000 + 32'(i * 4);
      @(posedge clk);
      #1;
      // R1 R2 R8: taken or not
      chk($sformatf("R1/R2 valid v%0d", i), 32'(entry_valid), 32'(TBL[i].valid));
      chk($sformatf("R6 bank v%0d", i), 32'(bank_we), 32'(TBL[i].bank));
      if (TBL[i].valid) begin
        chk($sformatf("R3 mode v%0d", i), 32'(new_mode), 32'(TBL[i].mode));
        chk($sformatf("R4 vector v%0d", i), vector_pc, 32'(TBL[i].vec));
        chk($sformatf("R5 newpsr v%0d", i), new_psr,
            exp_psr(TBL[i].psr, TBL[i].mode, TBL[i].setf));
        if (TBL[i].bank != 0) begin
          chk($sformatf("R6 saved v%0d", i), saved_psr, TBL[i].psr);
          chk($sformatf("R6 link v%0d", i), link_addr, cur_pc);
        end else begin
          // R7 reset entry writes no bank
          chk($sformatf("R7 nobank v%0d", i), 32'(bank_we), 0);
        end
      end else begin
        // R9 ignored request leaves state
        chk($sformatf("R9 hold mode v%0d", i), 32'(new_mode), 32'(last_mode));
        chk($sformatf("R9 hold vec v%0d", i), vector_pc, last_vec);
        chk($sformatf("R9 hold psr v%0d", i), new_psr, last_psr);
        chk($sformatf("R9 hold saved v%0d", i), saved_psr, last_saved);
        chk($sformatf("R9 hold link v%0d", i), link_addr, last_link);
      end
    end

    // R9 idle cycle after an entry
    @(negedge clk);
    req = 7'b0010000; cur_psr = 32'h0000_0010; cur_pc = 32'h0000_1234;
    @(negedge clk);
    req = '0; cur_psr = 32'hFFFF_FF1F; cur_pc = 32'hDEAD_BEEF;
    @(posedge clk);
    #1;
    chk("R9 idle valid", 32'(entry_valid), 0);
    chk("R9 idle bank", 32'(bank_we), 0);
    chk("R9 idle mode", 32'(new_mode), 32'(5'b10001));
    chk("R9 idle link", link_addr, 32'h0000_1234);
    chk("R9 idle vec", vector_pc, 32'h1C);

    // R8 back-to-back entries, each one cycle later
    @(negedge clk);
    req = 7'b0000010; cur_psr = 32'h0000_0010; cur_pc = 32'h0000_0100;
    @(posedge clk);
    #1;
    chk("R8 b2b first vec", vector_pc, 32'h08);
    @(negedge clk);
    req = 7'b0100000; cur_pc = 32'h0000_0200;
    @(posedge clk);
    #1;
    chk("R8 b2b second valid", 32'(entry_valid), 1);
    chk("R8 b2b second vec", vector_pc, 32'h10);
    chk("R8 b2b second link", link_addr, 32'h0000_0200);

    // R10 synchronous reset clears outputs mid-run
    @(negedge clk);
    rst = 1'b1; req = 7'b0000001;
    @(posedge clk);
    #1;
    chk("R10 sync clear valid", 32'(entry_valid), 0);
    chk("R10 sync clear vec", vector_pc, 0);
    chk("R10 sync clear link", link_addr, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule